// File: doc/BRIEF.md
# Four-Bit Arithmetic Logic Unit with Lookahead Carry

The block is a purely combinational arithmetic logic unit for a narrow datapath. A 3-bit operation code chooses one of eight functions of two 4-bit operands `a` and `b`. The unit drives a 4-bit result, a carry-out, and two status flags that describe the result: equal to zero, and greater than zero when the result is read as a signed number.

Addition uses a carry-lookahead network. Every carry is written as a flat sum of products of the per-bit generate and propagate terms, so all carries resolve in two logic levels rather than rippling. Subtraction uses the same adder: operand `b` is inverted and the carry-in is forced high. Left shifts go through a barrel shifter. The shift amount is decoded to a one-hot select, and each select bit enables one fixed shift distance.

The block holds no state. A surrounding datapath drives the operands and the operation code and uses the outputs in the same cycle.

Top module: `alu4_core`

## Requirements
- R1: The operation code encoding is 000 ADD, 001 SUB, 010 AND, 011 OR, 100 NOT, 101 SLL, 110 pass B and 111 pass A. AND and OR act bit by bit on `a` and `b`. Pass B drives `b` to the result and pass A drives `a` to the result.
- R2: ADD drives `{carry_out, result}` to the 5-bit unsigned sum `a + b`.
- R3: SUB drives `result` to `(a - b) mod 16`. Its `carry_out` is 1 exactly when `a >= b` as unsigned numbers, because the adder sees `a + ~b + 1`.
- R4: NOT drives `result` to the bitwise inverse of `a`. Operand `b` has no effect.
- R5: SLL shifts `a` left by `b[1:0]` places and fills the vacated low bits with 0. A shift amount of 0 returns `a` unchanged, and `b[3:2]` has no effect.
- R6: `carry_out` is 0 for every operation code other than ADD and SUB.
- R7: `eq_zero` is 1 exactly when all four result bits are 0.
- R8: `gt_zero` is 1 exactly when result bit 3 is 0 and at least one of result bits 2..0 is 1.
- R9: All outputs are combinational functions of the present inputs. A new input value is reflected at the outputs in the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 3 | Operation code (encoding in R1) |
| a | input | 4 | First operand; the operand that is shifted or inverted |
| b | input | 4 | Second operand; its low two bits give the shift amount |
| result | output | 4 | Result of the selected operation |
| carry_out | output | 1 | Lookahead carry for ADD and SUB, 0 otherwise |
| eq_zero | output | 1 | Result is all zeros |
| gt_zero | output | 1 | Result is positive as a signed number |

## Verification
Every output is due in the same cycle that its inputs change, after zero clock edges. No result passes through a register. The bench applies each stimulus just after a falling clock edge. It waits one time unit for the logic to settle and then samples, which keeps every sample between clock edges and away from the edge itself. The checks cover a table of chosen vectors, every combination of operation code and operands, and directed cases for SUB borrow, a zero shift amount and the unused upper bits of `b`.

// File: rtl/alu4_pkg.sv
package alu4_pkg;

    localparam int DATA_W  = 4;
    localparam int SHAMT_W = $clog2(DATA_W);

    typedef enum logic [2:0] {
        OP_ADD   = 3'b000,
        OP_SUB   = 3'b001,
        OP_AND   = 3'b010,
        OP_OR    = 3'b011,
        OP_NOT   = 3'b100,
        OP_SHL   = 3'b101,
        OP_PASSB = 3'b110,
        OP_PASSA = 3'b111
    } alu_op_e;

    typedef struct packed {
        logic eq_zero;
        logic gt_zero;
    } alu_flags_t;

    typedef struct packed {
        logic [DATA_W-1:0] opa;
        logic [DATA_W-1:0] opb;
        logic              cin;
    } add_in_t;

    function automatic logic [DATA_W-1:0] onehot_dec(input logic [SHAMT_W-1:0] amt);
        logic [DATA_W-1:0] v;
        for (int i = 0; i < DATA_W; i++) begin
            v[i] = (amt == SHAMT_W'(i));
        end
        return v;
    endfunction

endpackage

// File: rtl/alu4_cla_adder.sv
module alu4_cla_adder
    import alu4_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W-1:0] gen;
    logic [W-1:0] prop;
    logic [W:0]   carry;

    assign gen  = opa & opb;
    assign prop = opa | opb;

    // Each carry is a flat OR of product terms: two logic levels.
    always_comb begin
        logic term;
        logic acc;
        carry[0] = cin;
        for (int i = 0; i < W; i++) begin
            term = cin;
            for (int k = 0; k <= i; k++) term = term & prop[k];
            acc = term;
            for (int j = 0; j <= i; j++) begin
                term = gen[j];
                for (int k = j + 1; k <= i; k++) term = term & prop[k];
                acc = acc | term;
            end
            carry[i+1] = acc;
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_sum
        assign sum[i] = opa[i] ^ opb[i] ^ carry[i];
    end

    assign cout = carry[W];
endmodule

// File: rtl/alu4_barrel_shl.sv
module alu4_barrel_shl
    import alu4_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int SW = SHAMT_W
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] amt,
    output logic [W-1:0]  dout
);
    logic [W-1:0] sel;
    logic [W-1:0] stage [W];

    assign sel = onehot_dec(amt);

    for (genvar k = 0; k < W; k++) begin : g_dist
        assign stage[k] = sel[k] ? (din << k) : '0;
    end

    always_comb begin
        dout = '0;
        for (int k = 0; k < W; k++) dout = dout | stage[k];
    end
endmodule

// File: rtl/alu4_flags.sv
module alu4_flags
    import alu4_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] res,
    output alu_flags_t   flags
);
    assign flags.eq_zero = ~(|res);
    assign flags.gt_zero = ~(res[W-1] | ~(|res[W-2:0]));
endmodule

// File: rtl/alu4_core.sv
module alu4_core
    import alu4_pkg::*;
(
    input  logic [2:0]        op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] result,
    output logic              carry_out,
    output logic              eq_zero,
    output logic              gt_zero
);
    alu_op_e           opc;
    add_in_t           add_in;
    logic [DATA_W-1:0] add_sum;
    logic              add_cout;
    logic [DATA_W-1:0] shl_out;
    alu_flags_t        flags;

    assign opc = alu_op_e'(op);

    always_comb begin
        add_in.opa = a;
        add_in.opb = (opc == OP_SUB) ? ~b : b;
        add_in.cin = (opc == OP_SUB);
    end

    alu4_cla_adder #(.W(DATA_W)) i_add (
        .opa  (add_in.opa),
        .opb  (add_in.opb),
        .cin  (add_in.cin),
        .sum  (add_sum),
        .cout (add_cout)
    );

    alu4_barrel_shl #(.W(DATA_W), .SW(SHAMT_W)) i_shl (
        .din  (a),
        .amt  (b[SHAMT_W-1:0]),
        .dout (shl_out)
    );

    always_comb begin
        carry_out = 1'b0;
        unique case (opc)
            OP_ADD, OP_SUB: begin
                result    = add_sum;
                carry_out = add_cout;
            end
            OP_AND:   result = a & b;
            OP_OR:    result = a | b;
            OP_NOT:   result = ~a;
            OP_SHL:   result = shl_out;
            OP_PASSB: result = b;
            OP_PASSA: result = a;
            default:  result = '0;
        endcase
    end

    alu4_flags #(.W(DATA_W)) i_flg (
        .res   (result),
        .flags (flags)
    );

    assign eq_zero = flags.eq_zero;
    assign gt_zero = flags.gt_zero;
endmodule

// File: rtl/alu4_core_chk.sv
module alu4_core_chk
    import alu4_pkg::*;
(
    input logic [2:0]        op,
    input logic [DATA_W-1:0] a,
    input logic [DATA_W-1:0] b,
    input logic [DATA_W-1:0] result,
    input logic              carry_out,
    input logic              eq_zero,
    input logic              gt_zero
);
    always_comb begin
        if (op == 3'b000) begin
            assert_add_sum_R2: assert ({carry_out, result} == ({1'b0, a} + {1'b0, b}))
                else $error("R2 add mismatch");
        end
        if (op == 3'b001) begin
            assert_sub_diff_R3: assert (result == DATA_W'(a - b) && carry_out == (a >= b))
                else $error("R3 sub mismatch");
        end
        if (op == 3'b100) begin
            assert_not_inv_R4: assert ((result ^ a) == {DATA_W{1'b1}})
                else $error("R4 not mismatch");
        end
        if (op == 3'b101) begin
            assert_shl_amt_R5: assert (result == DATA_W'(a << b[SHAMT_W-1:0]))
                else $error("R5 shift mismatch");
        end
        if (op[2] | op[1]) begin
            assert_no_carry_R6: assert (!carry_out)
                else $error("R6 carry on non-arith op");
        end
        assert_flags_excl_R8: assert (!(eq_zero && gt_zero))
            else $error("R8 both flags set");
        assert_zero_flag_R7: assert (eq_zero == (result == '0))
            else $error("R7 zero flag mismatch");
    end
endmodule

bind alu4_core alu4_core_chk i_chk (.*);

// File: tb/test_alu4_core.sv
module test_alu4_core;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] op;
    logic [3:0] a, b;
    logic [3:0] result;
    logic       carry_out, eq_zero, gt_zero;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    alu4_core i_alu4_core (
        .op(op), .a(a), .b(b), .result(result),
        .carry_out(carry_out), .eq_zero(eq_zero), .gt_zero(gt_zero)
    );

    // {op, a, b, result, carry, eq, gt}
    localparam int NV = 17;
    localparam logic [17:0] VEC [NV] = '{
        {3'b000, 4'h3, 4'h4, 4'h7, 1'b0, 1'b0, 1'b1},
        {3'b000, 4'h9, 4'h7, 4'h0, 1'b1, 1'b1, 1'b0},
        {3'b000, 4'hF, 4'hF, 4'hE, 1'b1, 1'b0, 1'b0},
        {3'b001, 4'h5, 4'h3, 4'h2, 1'b1, 1'b0, 1'b1},
        {3'b001, 4'h3, 4'h5, 4'hE, 1'b0, 1'b0, 1'b0},
        {3'b001, 4'h6, 4'h6, 4'h0, 1'b1, 1'b1, 1'b0},
        {3'b010, 4'hC, 4'hA, 4'h8, 1'b0, 1'b0, 1'b0},
        {3'b011, 4'h4, 4'h2, 4'h6, 1'b0, 1'b0, 1'b1},
        {3'b100, 4'h5, 4'h0, 4'hA, 1'b0, 1'b0, 1'b0},
        {3'b100, 4'hF, 4'h9, 4'h0, 1'b0, 1'b1, 1'b0},
        {3'b101, 4'h3, 4'h1, 4'h6, 1'b0, 1'b0, 1'b1},
        {3'b101, 4'h7, 4'h7, 4'h8, 1'b0, 1'b0, 1'b0},
        {3'b101, 4'hB, 4'hC, 4'hB, 1'b0, 1'b0, 1'b0},
        {3'b101, 4'h1, 4'h6, 4'h4, 1'b0, 1'b0, 1'b1},
        {3'b110, 4'h9, 4'h3, 4'h3, 1'b0, 1'b0, 1'b1},
        {3'b111, 4'h9, 4'h3, 4'h9, 1'b0, 1'b0, 1'b0},
        {3'b111, 4'h0, 4'h5, 4'h0, 1'b0, 1'b1, 1'b0}
    };

    function automatic string tag_of(input logic [2:0] o);
        case (o)
            3'b000:  return "R2";
            3'b001:  return "R3";
            3'b100:  return "R4";
            3'b101:  return "R5";
            default: return "R1";
        endcase
    endfunction

    task automatic apply(input logic [2:0] o, input logic [3:0] x, input logic [3:0] y);
        @(negedge clk);
        op = o; a = x; b = y;
        #1;
    endtask

    task automatic check(input string req, input logic [6:0] got, input logic [6:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s op=%b a=%h b=%h got=%h expected=%h", req, op, a, b, got, exp);
        end
    endtask

    function automatic logic [6:0] model(input logic [2:0] o, input logic [3:0] x, input logic [3:0] y);
        logic [3:0] r;
        logic       c;
        logic [4:0] s;
        c = 1'b0;
        case (o)
            3'b000: begin s = x + y; r = s[3:0]; c = s[4]; end
            3'b001: begin r = x - y; c = (x >= y); end
            3'b010: r = x & y;
            3'b011: r = x | y;
            3'b100: r = ~x;
            3'b101: r = x << y[1:0];
            3'b110: r = y;
            default: r = x;
        endcase
        return {r, c, (r == 4'h0), (r[3] == 1'b0 && r != 4'h0)};
    endfunction

    initial begin
        op = 3'b000; a = 4'h0; b = 4'h0;
        repeat (3) @(posedge clk);
        // Reset: all-zero ADD gives zero result, no carry, zero flag (R7, R9)
        #1;
        check("R7", {result, carry_out, eq_zero, gt_zero}, 7'b0000_0_1_0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][17:15], VEC[i][14:11], VEC[i][10:7]);
            check(tag_of(VEC[i][17:15]), {result, carry_out, eq_zero, gt_zero}, VEC[i][6:0]);
        end

        // Same-cycle response: change input without any clock edge (R9)
        apply(3'b000, 4'h1, 4'h1);
        a = 4'h2; #1;
        check("R9", {result, carry_out, eq_zero, gt_zero}, model(3'b000, 4'h2, 4'h1));

        // SUB borrow boundary: 0 - 1 gives F with carry 0 (R3)
        apply(3'b001, 4'h0, 4'h1);
        check("R3", {result, carry_out, eq_zero, gt_zero}, 7'b1111_0_0_0);

        // NOT ignores b (R4)
        apply(3'b100, 4'h6, 4'hF);
        check("R4", {result, carry_out, eq_zero, gt_zero}, 7'b1001_0_0_0);

        // SLL upper b bits ignored, zero amount returns a (R5)
        apply(3'b101, 4'hD, 4'hC);
        check("R5", {result, carry_out, eq_zero, gt_zero}, 7'b1101_0_0_0);

        // gt flag boundary: 0111 positive, 1000 not (R8)
        apply(3'b111, 4'h7, 4'h0);
        check("R8", {result, carry_out, eq_zero, gt_zero}, 7'b0111_0_0_1);
        apply(3'b111, 4'h8, 4'h0);
        check("R8", {result, carry_out, eq_zero, gt_zero}, 7'b1000_0_0_0);

        // Non-arith with operands that would carry under ADD (R6)
        apply(3'b011, 4'hF, 4'hF);
        check("R6", {result, carry_out, eq_zero, gt_zero}, 7'b1111_0_0_0);

        // Exhaustive sweep against independent model
        for (int o = 0; o < 8; o++) begin
            for (int x = 0; x < 16; x++) begin
                for (int y = 0; y < 16; y++) begin
                    apply(3'(o), 4'(x), 4'(y));
                    check(tag_of(3'(o)), {result, carry_out, eq_zero, gt_zero},
                          model(3'(o), 4'(x), 4'(y)));
                end
            end
        end

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired got=running expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule